// File: doc/BRIEF.md
# Accelerator Acquisition CSR File

This block is the host-side register set that lets a hart claim remote accelerator managers and steer its custom instructions to them. It has a set of configuration slots, sixteen by default. Each slot names a physical manager and carries a claim bit. Writing the claim bit as 1 sends an acquire request toward the response-channel fabric. The claim bit reads back as 1 only after that manager has answered with a success result. Clearing the claim bit on a held slot sends a release request and frees the slot at once.

Four opcode-map registers, one per custom opcode class, each pick the slot that serves that class. When a custom instruction issues, the block looks up its opcode class, then the slot, then the slot's manager. One cycle later it returns the routing decision. If the chosen slot is not held, it raises an illegal-instruction flag in place of the routing decision. A barrier register holds the slot index that the next memory fence applies to. Message framing and the interconnect sit outside this block.

Top module: `acc_bind_csr`

## Requirements
- R1: After reset, every slot, every opcode-map register and the barrier register read as 0, `fence_slot` is 0, and no request, route or illegal strobe is active.
- R2: Address decode is as follows. Opcode-map registers for classes 0 to 3 sit at 0x800 to 0x803, the barrier register at 0x804, and slots 0 to 15 at 0x810 to 0x81F. Any other address gives `csr_hit`=0 and `csr_rdata`=0, and writes to it change no register.
- R3: A slot reads as follows. Bits [7:0] hold the manager ID, bit 8 is 1 only while the slot is held, and all higher bits are 0.
- R4: A write with bit 8 set to a free slot does two things. The cycle after the write, it raises `acq_req_valid` for one cycle, with `req_slot` set to the slot index and `req_mgr` set to the written bits [7:0]. It also stores the manager ID. While the slot waits for its answer, bit 8 reads as 0.
- R5: An acquire result for a waiting slot with `acq_resp_ok`=1 makes the slot read bit 8 = 1 from the next cycle. A result with `acq_resp_ok`=0 returns the slot to free. A result for a slot that is not waiting has no effect.
- R6: While a slot is waiting or held, its manager ID cannot change. Every write to a waiting slot is ignored.
- R7: A write with bit 8 clear to a held slot raises `rel_req_valid` for one cycle in the next cycle, with the slot index and its manager ID. From then on the slot reads as not held.
- R8: A write with bit 8 clear to a free slot only updates the manager ID and raises no request.
- R9: An instruction with `inst_valid` and class k makes the next cycle carry `route_valid`=1, with `route_slot` set to the slot held in map register k and `route_mgr` set to that slot's manager, provided the slot is held at issue.
- R10: If the mapped slot is not held at issue, the next cycle carries `illegal_inst`=1 and `route_valid`=0. `route_slot` and `route_mgr` still show the looked-up slot and its manager.
- R11: Opcode-map and barrier registers keep only written bits [3:0]. `fence_slot` presents the barrier value.
- R12: At most one of `acq_req_valid` and `rel_req_valid` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_en | input | 1 | CSR access this cycle |
| csr_we | input | 1 | Access is a write |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | 64 | Write data |
| csr_rdata | output | 64 | Read data (combinational) |
| csr_hit | output | 1 | Address belongs to this block |
| inst_valid | input | 1 | Custom instruction issued |
| inst_opc | input | 2 | Custom opcode class 0..3 |
| route_valid | output | 1 | Instruction forwarded |
| illegal_inst | output | 1 | Instruction refused, slot not held |
| route_slot | output | 4 | Slot looked up |
| route_mgr | output | 8 | Manager of that slot |
| acq_req_valid | output | 1 | Acquire request strobe |
| rel_req_valid | output | 1 | Release request strobe |
| req_slot | output | 4 | Slot of the request |
| req_mgr | output | 8 | Manager of the request |
| acq_resp_valid | input | 1 | Acquire result arrives |
| acq_resp_slot | input | 4 | Slot the result belongs to |
| acq_resp_ok | input | 1 | 1 = acquire succeeded |
| fence_slot | output | 4 | Barrier slot index |

## Verification
On every cycle, the assertions check the following. The two request strobes never overlap, and each strobe traces back to a slot write of the right polarity. A slot's manager ID is frozen while the slot is waiting or held. A waiting slot becomes held only on a success result. Every routing or illegal pulse follows an issued instruction. The scoreboard scenarios are needed for the rest: the full chain from opcode class through map register and slot to manager, the read-back of the claim bit across the wait, failure and release, the ignored writes and stray results, and the top-slot boundary.

// File: rtl/acc_bind_pkg.sv
package acc_bind_pkg;
  localparam int unsigned CSR_AW = 12;
  localparam logic [CSR_AW-1:0] OPMAP_BASE  = 12'h800;
  localparam logic [CSR_AW-1:0] BARRIER_ADR = 12'h804;
  localparam logic [CSR_AW-1:0] SLOT_BASE   = 12'h810;

  typedef enum logic [1:0] {
    SLOT_FREE = 2'd0,
    SLOT_WAIT = 2'd1,
    SLOT_HELD = 2'd2
  } slot_st_e;
endpackage

// File: rtl/acc_slot.sv
module acc_slot
  import acc_bind_pkg::*;
#(
  parameter int unsigned MGR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_claim,
  input  logic [MGR_W-1:0] wr_mgr,
  input  logic             resp_en,
  input  logic             resp_ok,
  output logic             is_free,
  output logic             is_held,
  output logic [MGR_W-1:0] mgr
);
  slot_st_e         st_q, st_d;
  logic [MGR_W-1:0] mgr_q;
  logic             mgr_en;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      SLOT_FREE: if (wr_en && wr_claim) st_d = SLOT_WAIT;
      SLOT_WAIT: if (resp_en) st_d = resp_ok ? SLOT_HELD : SLOT_FREE;
      SLOT_HELD: if (wr_en && !wr_claim) st_d = SLOT_FREE;
      default:   st_d = SLOT_FREE;
    endcase
  end

  assign mgr_en = wr_en && (st_q == SLOT_FREE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SLOT_FREE;
      mgr_q <= '0;
    end else begin
      st_q <= st_d;
      if (mgr_en) mgr_q <= wr_mgr;
    end
  end

  assign is_free = (st_q == SLOT_FREE);
  assign is_held = (st_q == SLOT_HELD);
  assign mgr     = mgr_q;

  // R6: manager ID frozen while waiting or held
  p_mgr_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != SLOT_FREE) |=> $stable(mgr_q));
  // R6: a waiting slot stays waiting until a result arrives
  p_wait_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SLOT_WAIT && !resp_en) |=> (st_q == SLOT_WAIT));
  // R5: held only after a success result
  p_grant_needs_ok_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SLOT_WAIT && !(resp_en && resp_ok)) |=> (st_q != SLOT_HELD));
endmodule

// File: rtl/acc_opmap.sv
module acc_opmap #(
  parameter int unsigned NUM_OPC   = 4,
  parameter int unsigned NUM_SLOTS = 16,
  parameter int unsigned MGR_W     = 8,
  localparam int unsigned IDX_W    = $clog2(NUM_SLOTS),
  localparam int unsigned OPC_W    = $clog2(NUM_OPC)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_OPC-1:0]              map_wr,
  input  logic                            bar_wr,
  input  logic [IDX_W-1:0]                wr_idx,
  input  logic                            inst_valid,
  input  logic [OPC_W-1:0]                inst_opc,
  input  logic [NUM_SLOTS-1:0]            slot_held,
  input  logic [NUM_SLOTS-1:0][MGR_W-1:0] slot_mgr,
  output logic [NUM_OPC-1:0][IDX_W-1:0]   map_val,
  output logic [IDX_W-1:0]                bar_val,
  output logic                            route_valid,
  output logic                            illegal_inst,
  output logic [IDX_W-1:0]                route_slot,
  output logic [MGR_W-1:0]                route_mgr
);
  logic [IDX_W-1:0] bar_q;
  logic [IDX_W-1:0] sel;
  logic             rt_ok_d, rt_bad_d;
  logic             rt_ok_q, rt_bad_q;
  logic [IDX_W-1:0] rt_slot_q;
  logic [MGR_W-1:0] rt_mgr_q;

  for (genvar k = 0; k < NUM_OPC; k++) begin : g_map
    logic [IDX_W-1:0] map_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         map_q <= '0;
      else if (map_wr[k]) map_q <= wr_idx;
    end
    assign map_val[k] = map_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bar_q <= '0;
    else if (bar_wr) bar_q <= wr_idx;
  end
  assign bar_val = bar_q;

  assign sel      = map_val[inst_opc];
  assign rt_ok_d  = inst_valid &&  slot_held[sel];
  assign rt_bad_d = inst_valid && !slot_held[sel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rt_ok_q   <= 1'b0;
      rt_bad_q  <= 1'b0;
      rt_slot_q <= '0;
      rt_mgr_q  <= '0;
    end else begin
      rt_ok_q  <= rt_ok_d;
      rt_bad_q <= rt_bad_d;
      if (inst_valid) begin
        rt_slot_q <= sel;
        rt_mgr_q  <= slot_mgr[sel];
      end
    end
  end

  assign route_valid  = rt_ok_q;
  assign illegal_inst = rt_bad_q;
  assign route_slot   = rt_slot_q;
  assign route_mgr    = rt_mgr_q;

  // R9/R10: every decision follows an issued instruction
  p_route_follows_inst_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (route_valid || illegal_inst) |-> $past(inst_valid));
  // R10: a refused instruction is never also forwarded
  p_refuse_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({route_valid, illegal_inst}));
  // R11: barrier value changes only on a barrier write
  p_bar_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !bar_wr |=> $stable(bar_val));
endmodule

// File: rtl/acc_bind_csr.sv
module acc_bind_csr
  import acc_bind_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 16,
  parameter int unsigned NUM_OPC   = 4,
  parameter int unsigned MGR_W     = 8,
  parameter int unsigned XLEN      = 64,
  localparam int unsigned IDX_W    = $clog2(NUM_SLOTS),
  localparam int unsigned OPC_W    = $clog2(NUM_OPC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_en,
  input  logic              csr_we,
  input  logic [11:0]       csr_addr,
  input  logic [XLEN-1:0]   csr_wdata,
  output logic [XLEN-1:0]   csr_rdata,
  output logic              csr_hit,
  input  logic              inst_valid,
  input  logic [OPC_W-1:0]  inst_opc,
  output logic              route_valid,
  output logic              illegal_inst,
  output logic [IDX_W-1:0]  route_slot,
  output logic [MGR_W-1:0]  route_mgr,
  output logic              acq_req_valid,
  output logic              rel_req_valid,
  output logic [IDX_W-1:0]  req_slot,
  output logic [MGR_W-1:0]  req_mgr,
  input  logic              acq_resp_valid,
  input  logic [IDX_W-1:0]  acq_resp_slot,
  input  logic              acq_resp_ok,
  output logic [IDX_W-1:0]  fence_slot
);
  localparam int unsigned CLAIM_BIT = MGR_W;

  logic                            wr;
  logic                            hit_map, hit_bar, hit_slot;
  logic [IDX_W-1:0]                slot_off;
  logic [OPC_W-1:0]                map_off;
  logic [NUM_OPC-1:0]              map_wr;
  logic [NUM_SLOTS-1:0]            slot_free, slot_held;
  logic [NUM_SLOTS-1:0][MGR_W-1:0] slot_mgr;
  logic [NUM_OPC-1:0][IDX_W-1:0]   map_val;
  logic [IDX_W-1:0]                bar_val;
  logic                            acq_fire, rel_fire;
  logic                            acq_q, rel_q;
  logic [IDX_W-1:0]                rq_slot_q;
  logic [MGR_W-1:0]                rq_mgr_q, rq_mgr_d;

  assign wr       = csr_en && csr_we;
  assign slot_off = csr_addr[IDX_W-1:0];
  assign map_off  = csr_addr[OPC_W-1:0];
  assign hit_map  = (csr_addr[11:OPC_W] == OPMAP_BASE[11:OPC_W]);
  assign hit_bar  = (csr_addr == BARRIER_ADR);
  assign hit_slot = (csr_addr[11:4] == SLOT_BASE[11:4]) &&
                    (32'(csr_addr[3:0]) < NUM_SLOTS);
  assign csr_hit  = csr_en && (hit_map || hit_bar || hit_slot);

  for (genvar k = 0; k < NUM_OPC; k++) begin : g_mapwr
    assign map_wr[k] = wr && hit_map && (map_off == OPC_W'(k));
  end

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    acc_slot #(.MGR_W(MGR_W)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr && hit_slot && (slot_off == IDX_W'(i))),
      .wr_claim (csr_wdata[CLAIM_BIT]),
      .wr_mgr   (csr_wdata[MGR_W-1:0]),
      .resp_en  (acq_resp_valid && (acq_resp_slot == IDX_W'(i))),
      .resp_ok  (acq_resp_ok),
      .is_free  (slot_free[i]),
      .is_held  (slot_held[i]),
      .mgr      (slot_mgr[i])
    );
  end

  acc_opmap #(
    .NUM_OPC  (NUM_OPC),
    .NUM_SLOTS(NUM_SLOTS),
    .MGR_W    (MGR_W)
  ) u_opmap (
    .clk         (clk),
    .rst_n       (rst_n),
    .map_wr      (map_wr),
    .bar_wr      (wr && hit_bar),
    .wr_idx      (csr_wdata[IDX_W-1:0]),
    .inst_valid  (inst_valid),
    .inst_opc    (inst_opc),
    .slot_held   (slot_held),
    .slot_mgr    (slot_mgr),
    .map_val     (map_val),
    .bar_val     (bar_val),
    .route_valid (route_valid),
    .illegal_inst(illegal_inst),
    .route_slot  (route_slot),
    .route_mgr   (route_mgr)
  );

  // request strobes
  assign acq_fire = wr && hit_slot &&  csr_wdata[CLAIM_BIT] && slot_free[slot_off];
  assign rel_fire = wr && hit_slot && !csr_wdata[CLAIM_BIT] && slot_held[slot_off];
  assign rq_mgr_d = acq_fire ? csr_wdata[MGR_W-1:0] : slot_mgr[slot_off];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acq_q     <= 1'b0;
      rel_q     <= 1'b0;
      rq_slot_q <= '0;
      rq_mgr_q  <= '0;
    end else begin
      acq_q <= acq_fire;
      rel_q <= rel_fire;
      if (acq_fire || rel_fire) begin
        rq_slot_q <= slot_off;
        rq_mgr_q  <= rq_mgr_d;
      end
    end
  end

  assign acq_req_valid = acq_q;
  assign rel_req_valid = rel_q;
  assign req_slot      = rq_slot_q;
  assign req_mgr       = rq_mgr_q;
  assign fence_slot    = bar_val;

  // read mux
  always_comb begin
    csr_rdata = '0;
    if (csr_en) begin
      if (hit_map)
        csr_rdata[IDX_W-1:0] = map_val[map_off];
      else if (hit_bar)
        csr_rdata[IDX_W-1:0] = bar_val;
      else if (hit_slot) begin
        csr_rdata[MGR_W-1:0] = slot_mgr[slot_off];
        csr_rdata[CLAIM_BIT] = slot_held[slot_off];
      end
    end
  end

  // R12: the two request strobes never coincide
  p_one_strobe_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({acq_req_valid, rel_req_valid}));
  // R4: an acquire strobe follows a claiming write
  p_acq_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    acq_req_valid |-> $past(csr_en && csr_we && csr_wdata[CLAIM_BIT]));
  // R7: a release strobe follows a clearing write
  p_rel_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rel_req_valid |-> $past(csr_en && csr_we && !csr_wdata[CLAIM_BIT]));
  // R2: unmapped addresses return zero
  p_miss_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !csr_hit |-> (csr_rdata == '0));
endmodule

// File: tb/acc_bind_csr_bench.sv
module acc_bind_csr_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        csr_en, csr_we;
  logic [11:0] csr_addr;
  logic [63:0] csr_wdata, csr_rdata;
  logic        csr_hit;
  logic        inst_valid;
  logic [1:0]  inst_opc;
  logic        route_valid, illegal_inst;
  logic [3:0]  route_slot;
  logic [7:0]  route_mgr;
  logic        acq_req_valid, rel_req_valid;
  logic [3:0]  req_slot;
  logic [7:0]  req_mgr;
  logic        acq_resp_valid;
  logic [3:0]  acq_resp_slot;
  logic        acq_resp_ok;
  logic [3:0]  fence_slot;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  typedef struct { int kind; int slot; int mgr; string req; } exp_t;
  // kind: 0 acquire, 1 release, 2 route, 3 illegal
  exp_t sb_q[$];

  always #4 clk = ~clk;

  acc_bind_csr u_acc_bind_csr (
    .clk(clk), .rst_n(rst_n), .csr_en(csr_en), .csr_we(csr_we),
    .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .csr_hit(csr_hit), .inst_valid(inst_valid), .inst_opc(inst_opc),
    .route_valid(route_valid), .illegal_inst(illegal_inst),
    .route_slot(route_slot), .route_mgr(route_mgr),
    .acq_req_valid(acq_req_valid), .rel_req_valid(rel_req_valid),
    .req_slot(req_slot), .req_mgr(req_mgr),
    .acq_resp_valid(acq_resp_valid), .acq_resp_slot(acq_resp_slot),
    .acq_resp_ok(acq_resp_ok), .fence_slot(fence_slot)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic expect_ev(int kind, int slot, int mgr, string req);
    exp_t e;
    e.kind = kind; e.slot = slot; e.mgr = mgr; e.req = req;
    sb_q.push_back(e);
  endtask

  // monitor: pops expected items as outputs appear
  always @(negedge clk) begin
    if (rst_n === 1'b1 &&
        (acq_req_valid || rel_req_valid || route_valid || illegal_inst)) begin
      int kind;
      kind = acq_req_valid ? 0 : rel_req_valid ? 1 : route_valid ? 2 : 3;
      if (sb_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL unexpected event kind %0d: actual present expected none (R8/R6/R5)", kind);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        chk({e.req, " kind"}, 64'(kind), 64'(e.kind));
        if (kind < 2) begin
          chk({e.req, " req_slot"}, 64'(req_slot), 64'(e.slot));
          chk({e.req, " req_mgr"},  64'(req_mgr),  64'(e.mgr));
        end else begin
          chk({e.req, " route_slot"}, 64'(route_slot), 64'(e.slot));
          chk({e.req, " route_mgr"},  64'(route_mgr),  64'(e.mgr));
        end
      end
    end
  end

  task automatic csr_wr(logic [11:0] a, logic [63:0] d);
    @(negedge clk);
    csr_en = 1'b1; csr_we = 1'b1; csr_addr = a; csr_wdata = d;
    @(negedge clk);
    csr_en = 1'b0; csr_we = 1'b0;
  endtask

  task automatic csr_rd(logic [11:0] a, logic [63:0] exp, logic exp_hit, string req);
    @(negedge clk);
    csr_en = 1'b1; csr_we = 1'b0; csr_addr = a;
    #1;
    chk({req, " rdata"}, csr_rdata, exp);
    chk({req, " hit"}, 64'(csr_hit), 64'(exp_hit));
    csr_en = 1'b0;
  endtask

  task automatic resp(logic [3:0] s, logic ok);
    @(negedge clk);
    acq_resp_valid = 1'b1; acq_resp_slot = s; acq_resp_ok = ok;
    @(negedge clk);
    acq_resp_valid = 1'b0;
  endtask

  task automatic issue(logic [1:0] opc, int kind, int slot, int mgr, string req);
    expect_ev(kind, slot, mgr, req);
    @(negedge clk);
    inst_valid = 1'b1; inst_opc = opc;
    @(negedge clk);
    inst_valid = 1'b0;
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; csr_en = 0; csr_we = 0; csr_addr = '0; csr_wdata = '0;
    inst_valid = 0; inst_opc = '0;
    acq_resp_valid = 0; acq_resp_slot = '0; acq_resp_ok = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset values
    for (int k = 0; k < 5; k++) csr_rd(12'h800 + 12'(k), 64'h0, 1'b1, "R1 map/bar");
    csr_rd(12'h810, 64'h0, 1'b1, "R1 slot0");
    csr_rd(12'h81F, 64'h0, 1'b1, "R1 slot15");
    chk("R1 fence_slot", 64'(fence_slot), 64'h0);
    chk("R1 strobes", 64'({acq_req_valid, rel_req_valid, route_valid, illegal_inst}), 64'h0);

    // R2: unmapped addresses
    csr_rd(12'h805, 64'h0, 1'b0, "R2 0x805");
    csr_rd(12'h820, 64'h0, 1'b0, "R2 0x820");
    csr_wr(12'h805, 64'hF);
    csr_wr(12'h80F, 64'hF);
    for (int k = 0; k < 5; k++) csr_rd(12'h800 + 12'(k), 64'h0, 1'b1, "R2 no side effect");

    // R8: idle slot write without claim sets manager only
    csr_wr(12'h813, 64'h05A);
    csr_rd(12'h813, 64'h05A, 1'b1, "R8 mgr only");

    // R4: claim, pending reads 0 in bit 8
    expect_ev(0, 3, 8'hA7, "R4 acquire strobe");
    csr_wr(12'h813, 64'h1A7);
    csr_rd(12'h813, 64'h0A7, 1'b1, "R4 pending read");
    // R6: write to waiting slot ignored
    csr_wr(12'h813, 64'h0FF);
    csr_rd(12'h813, 64'h0A7, 1'b1, "R6 pending write ignored");

    // R5: stray result ignored
    resp(4'd5, 1'b1);
    csr_rd(12'h815, 64'h0, 1'b1, "R5 stray result");
    // R5: success
    resp(4'd3, 1'b1);
    csr_rd(12'h813, 64'h1A7, 1'b1, "R5 granted R3 format");

    // R11 + R9: map class 2 to slot 3, upper bits dropped
    csr_wr(12'h802, 64'hFFF3);
    csr_rd(12'h802, 64'h3, 1'b1, "R11 map bits");
    issue(2'd2, 2, 3, 8'hA7, "R9 route class2");
    // R10: class 0 maps slot 0, not held
    issue(2'd0, 3, 0, 8'h00, "R10 illegal class0");

    // R6: held slot manager locked, no new request
    csr_wr(12'h813, 64'h1C4);
    csr_rd(12'h813, 64'h1A7, 1'b1, "R6 held mgr locked");

    // R5: failure path
    expect_ev(0, 7, 8'h11, "R4 acquire slot7");
    csr_wr(12'h817, 64'h111);
    resp(4'd7, 1'b0);
    csr_rd(12'h817, 64'h011, 1'b1, "R5 failed acquire");
    csr_wr(12'h801, 64'h7);
    issue(2'd1, 3, 7, 8'h11, "R10 failed slot refused");

    // R7: release
    expect_ev(1, 3, 8'hA7, "R7 release strobe");
    csr_wr(12'h813, 64'h000);
    csr_rd(12'h813, 64'h0A7, 1'b1, "R7 released read");
    issue(2'd2, 3, 3, 8'hA7, "R10 after release");

    // R11: barrier
    csr_wr(12'h804, 64'hAB);
    csr_rd(12'h804, 64'hB, 1'b1, "R11 barrier read");
    chk("R11 fence_slot", 64'(fence_slot), 64'hB);

    // top slot boundary, R12 single strobe exercised by sequence
    expect_ev(0, 15, 8'hFE, "R12 acquire slot15");
    csr_wr(12'h81F, 64'h1FE);
    resp(4'd15, 1'b1);
    csr_rd(12'h81F, 64'h1FE, 1'b1, "R3 slot15");
    csr_wr(12'h803, 64'hF);
    issue(2'd3, 2, 15, 8'hFE, "R9 route slot15");

    repeat (3) @(negedge clk);
    chk("R12 scoreboard drained", 64'(sb_q.size()), 64'h0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule